// File: doc/BRIEF.md
# Mesh Hit Record Router

This block is the forwarding stage of one node in a two-dimensional mesh of readout chips. Each node runs from its own free-running clock. Hit records come from two places: the node's own front end, and the four neighbours (north, east, south, west). Local hits enter as channel plus timestamp. The router stamps them with the node's mesh coordinates and queues them in a local FIFO. Records that arrive from neighbours already carry their origin coordinates. They pass through a small elastic buffer on each link, are merged into one remote FIFO, and later leave unchanged.

A single output scheduler takes turns between the local and remote queues. It presents each record on the one neighbour link chosen by a configuration input. Each node points toward the data-acquisition exit, so the mesh forms a tree with that exit node at its root. A failed neighbour is bypassed by changing the direction input. A record that is still waiting then moves to the new link and is sent exactly once.

Every data stream uses valid/ready handshaking, and a transfer happens on a clock edge where both are high. A sender holds valid and data steady until the transfer happens. Valid never depends on ready. On the transmit side, the record held on the selected link stays steady for as long as that link's ready is low. The only exception is a change of the direction input: valid then moves to the newly selected link, and the abandoned link sees valid drop without a transfer. The receive ready of a link drops only when that link's elastic buffer is full. The local ready drops only when the local FIFO is full.

Top module: `mesh_hit_router`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all `tx_valid` are low. Out of reset, `local_ready` is high and all four `rx_ready` are high.
- R2: A local hit leaves the block as a record laid out as follows: x coordinate in bits [45:42], y coordinate in bits [41:38], channel in bits [37:32] and timestamp in bits [31:0]. The coordinates are the values on `my_x`/`my_y` when the record is taken for output.
- R3: A record received on any neighbour link is transmitted with all 46 bits unchanged.
- R4: Only the link selected by `dir_cfg` asserts `tx_valid`. The encoding is 0 north, 1 east, 2 south and 3 west, and link index i carries direction code i.
- R5: While the selected link's `tx_ready` is low, `tx_valid` stays high and `tx_data` stays unchanged. Each record is sent exactly once.
- R6: If `dir_cfg` changes while a record is waiting, that record is offered on the newly selected link and is sent once, on that link only.
- R7: When both queues hold records, the scheduler alternates between local and remote. After reset it serves local first.
- R8: With the output blocked, the block accepts exactly LOCAL_DEPTH + 1 local hits. `local_ready` then stays low, and after release every accepted hit leaves in arrival order.
- R9: When several links deliver records in the same cycle, they are merged in rotating order, starting from the link after the one served last.
- R10: A link's `rx_ready` falls only on the cycle after a record was accepted on that link, and it stays high while its elastic buffer (LINK_DEPTH entries) has room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Node clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_x | input | 4 | Mesh x coordinate of this node |
| my_y | input | 4 | Mesh y coordinate of this node |
| dir_cfg | input | 2 | Output direction: 0 N, 1 E, 2 S, 3 W |
| local_valid | input | 1 | Local hit offered |
| local_ready | output | 1 | Local hit accepted when high with valid |
| local_hit | input | 38 | Channel [37:32] and timestamp [31:0] |
| rx_valid | input | 4 | Per-link receive valid |
| rx_ready | output | 4 | Per-link receive ready |
| rx_data | input | 4x46 | Per-link received record |
| tx_valid | output | 4 | Per-link transmit valid |
| tx_ready | input | 4 | Per-link transmit ready |
| tx_data | output | 4x46 | Per-link transmitted record |

## Verification
The bench fills both queues while the output is blocked and then checks the strict local/remote alternation. A design with a fixed priority would send the three local records back to back. It overfills the local queue and counts the accepted hits. A FIFO with an off-by-one full flag would take one hit too many and overwrite it, or take one too few. It changes the direction while a record is stalled, which catches a design that drops the record or sends it on the old link as well as the new one. It also drives all four links in the same cycle and checks the rotation, which a fixed-priority merge would break.

// File: rtl/mesh_rt_pkg.sv
package mesh_rt_pkg;
  parameter int COORD_W = 4;
  parameter int CHAN_W  = 6;
  parameter int TS_W    = 32;
  parameter int NLINK   = 4;
  localparam int HIT_W  = CHAN_W + TS_W;
  localparam int REC_W  = 2 * COORD_W + HIT_W;
  localparam int DIR_W  = $clog2(NLINK);

  typedef enum logic [DIR_W-1:0] {
    DIR_NORTH = 2'd0,
    DIR_EAST  = 2'd1,
    DIR_SOUTH = 2'd2,
    DIR_WEST  = 2'd3
  } dir_e;
endpackage

// File: rtl/mesh_fifo.sv
module mesh_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full     = (cnt_q == CW'(DEPTH));
  assign empty    = (cnt_q == '0);
  assign do_push  = push && !full;
  assign do_pop   = pop && !empty;
  assign pop_data = mem[rd_q];

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= step(wr_q);
      if (do_pop)  rd_q <= step(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/mesh_rx_arb.sv
module mesh_rx_arb #(
  parameter int NLINK = 4,
  parameter int W     = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NLINK-1:0]          buf_empty,
  input  logic [NLINK-1:0][W-1:0]   buf_data,
  output logic [NLINK-1:0]          buf_pop,
  input  logic                      dst_full,
  output logic                      dst_push,
  output logic [W-1:0]              dst_data
);
  localparam int IW = (NLINK > 1) ? $clog2(NLINK) : 1;

  logic [IW-1:0] last_q, gsel;
  logic          found;

  always_comb begin
    int idx;
    found = 1'b0;
    gsel  = last_q;
    for (int off = 1; off <= NLINK; off++) begin
      idx = (int'(last_q) + off) % NLINK;
      if (!found && !buf_empty[idx]) begin
        found = 1'b1;
        gsel  = IW'(idx);
      end
    end
  end

  assign dst_push = found && !dst_full;
  assign dst_data = buf_data[gsel];

  always_comb begin
    buf_pop = '0;
    buf_pop[gsel] = dst_push;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        last_q <= IW'(NLINK - 1);
    else if (dst_push) last_q <= gsel;
  end
endmodule

// File: rtl/mesh_fwd_sched.sv
module mesh_fwd_sched
  import mesh_rt_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [COORD_W-1:0]          my_x,
  input  logic [COORD_W-1:0]          my_y,
  input  logic [DIR_W-1:0]            dir_cfg,
  input  logic                        local_empty,
  input  logic [HIT_W-1:0]            local_hit,
  output logic                        local_pop,
  input  logic                        remote_empty,
  input  logic [REC_W-1:0]            remote_rec,
  output logic                        remote_pop,
  output logic [NLINK-1:0]            tx_valid,
  input  logic [NLINK-1:0]            tx_ready,
  output logic [NLINK-1:0][REC_W-1:0] tx_data
);
  logic             out_valid_q, last_local_q;
  logic [REC_W-1:0] out_rec_q;
  logic [NLINK-1:0] sel;
  logic             accept, can_load, pick_local, pick_remote;

  assign sel         = NLINK'(1) << dir_cfg;
  assign accept      = out_valid_q && |(tx_ready & sel);
  assign can_load    = !out_valid_q || accept;
  assign pick_local  = !local_empty && (remote_empty || !last_local_q);
  assign pick_remote = !remote_empty && !pick_local;
  assign local_pop   = can_load && pick_local;
  assign remote_pop  = can_load && pick_remote;
  assign tx_valid    = out_valid_q ? sel : '0;

  for (genvar g = 0; g < NLINK; g++) begin : g_txd
    assign tx_data[g] = out_rec_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_q  <= 1'b0;
      last_local_q <= 1'b0;
      out_rec_q    <= '0;
    end else if (can_load) begin
      out_valid_q <= pick_local || pick_remote;
      if (pick_local) begin
        out_rec_q    <= {my_x, my_y, local_hit};
        last_local_q <= 1'b1;
      end else if (pick_remote) begin
        out_rec_q    <= remote_rec;
        last_local_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mesh_hit_router.sv
module mesh_hit_router
  import mesh_rt_pkg::*;
#(
  parameter int LOCAL_DEPTH  = 4,
  parameter int REMOTE_DEPTH = 8,
  parameter int LINK_DEPTH   = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [COORD_W-1:0]          my_x,
  input  logic [COORD_W-1:0]          my_y,
  input  logic [DIR_W-1:0]            dir_cfg,
  input  logic                        local_valid,
  output logic                        local_ready,
  input  logic [HIT_W-1:0]            local_hit,
  input  logic [NLINK-1:0]            rx_valid,
  output logic [NLINK-1:0]            rx_ready,
  input  logic [NLINK-1:0][REC_W-1:0] rx_data,
  output logic [NLINK-1:0]            tx_valid,
  input  logic [NLINK-1:0]            tx_ready,
  output logic [NLINK-1:0][REC_W-1:0] tx_data
);
  logic [NLINK-1:0]            lb_full, lb_empty, lb_pop;
  logic [NLINK-1:0][REC_W-1:0] lb_data;
  logic                        rq_full, rq_empty, rq_push, rq_pop;
  logic [REC_W-1:0]            rq_in, rq_out;
  logic                        lq_full, lq_empty, lq_pop;
  logic [HIT_W-1:0]            lq_out;

  for (genvar g = 0; g < NLINK; g++) begin : g_link
    mesh_fifo #(.W(REC_W), .DEPTH(LINK_DEPTH)) u_lbuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (rx_valid[g]),
      .push_data (rx_data[g]),
      .pop       (lb_pop[g]),
      .pop_data  (lb_data[g]),
      .full      (lb_full[g]),
      .empty     (lb_empty[g])
    );
    assign rx_ready[g] = !lb_full[g];
  end

  mesh_rx_arb #(.NLINK(NLINK), .W(REC_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .buf_empty (lb_empty),
    .buf_data  (lb_data),
    .buf_pop   (lb_pop),
    .dst_full  (rq_full),
    .dst_push  (rq_push),
    .dst_data  (rq_in)
  );

  mesh_fifo #(.W(REC_W), .DEPTH(REMOTE_DEPTH)) u_rq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (rq_push),
    .push_data (rq_in),
    .pop       (rq_pop),
    .pop_data  (rq_out),
    .full      (rq_full),
    .empty     (rq_empty)
  );

  mesh_fifo #(.W(HIT_W), .DEPTH(LOCAL_DEPTH)) u_lq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (local_valid),
    .push_data (local_hit),
    .pop       (lq_pop),
    .pop_data  (lq_out),
    .full      (lq_full),
    .empty     (lq_empty)
  );
  assign local_ready = !lq_full;

  mesh_fwd_sched u_sched (
    .clk          (clk),
    .rst_n        (rst_n),
    .my_x         (my_x),
    .my_y         (my_y),
    .dir_cfg      (dir_cfg),
    .local_empty  (lq_empty),
    .local_hit    (lq_out),
    .local_pop    (lq_pop),
    .remote_empty (rq_empty),
    .remote_rec   (rq_out),
    .remote_pop   (rq_pop),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .tx_data      (tx_data)
  );
endmodule

// File: rtl/mesh_hit_router_chk.sv
module mesh_hit_router_chk
  import mesh_rt_pkg::*;
(
  input logic                        clk,
  input logic                        rst_n,
  input logic [DIR_W-1:0]            dir_cfg,
  input logic                        local_valid,
  input logic                        local_ready,
  input logic [NLINK-1:0]            rx_valid,
  input logic [NLINK-1:0]            rx_ready,
  input logic [NLINK-1:0]            tx_valid,
  input logic [NLINK-1:0]            tx_ready,
  input logic [NLINK-1:0][REC_W-1:0] tx_data
);
  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> tx_valid == '0); // R1

  AST_ONE_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_valid) && (!(|tx_valid) || tx_valid[dir_cfg])); // R4

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (|(tx_valid & ~tx_ready)) |=> (|tx_valid) && $stable(tx_data)); // R5

  AST_LOCAL_FULL_ON_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(local_ready) |-> $past(local_valid)); // R8

  for (genvar g = 0; g < NLINK; g++) begin : g_rx
    AST_RX_ELASTIC: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_ready[g]) |-> $past(rx_valid[g])); // R10
  end
endmodule

bind mesh_hit_router mesh_hit_router_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dir_cfg     (dir_cfg),
  .local_valid (local_valid),
  .local_ready (local_ready),
  .rx_valid    (rx_valid),
  .rx_ready    (rx_ready),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .tx_data     (tx_data)
);

// File: tb/tb_mesh_hit_router.sv
module tb_mesh_hit_router;
  import mesh_rt_pkg::*;

  logic                        clk = 1'b0;
  logic                        rst_n = 1'b0;
  logic [COORD_W-1:0]          my_x = '0, my_y = '0;
  logic [DIR_W-1:0]            dir_cfg = '0;
  logic                        local_valid = 1'b0;
  logic                        local_ready;
  logic [HIT_W-1:0]            local_hit = '0;
  logic [NLINK-1:0]            rx_valid = '0;
  logic [NLINK-1:0]            rx_ready;
  logic [NLINK-1:0][REC_W-1:0] rx_data = '0;
  logic [NLINK-1:0]            tx_valid;
  logic [NLINK-1:0]            tx_ready = '0;
  logic [NLINK-1:0][REC_W-1:0] tx_data;

  int total = 0, bad = 0;
  logic [REC_W-1:0] mon_data [256];
  int               mon_dir  [256];
  int               mon_cnt = 0;

  always #5 clk = ~clk;

  mesh_hit_router dut (.*);

  always @(negedge clk) begin
    if (rst_n) begin
      for (int d = 0; d < NLINK; d++) begin
        if (tx_valid[d] && tx_ready[d] && mon_cnt < 256) begin
          mon_data[mon_cnt] = tx_data[d];
          mon_dir[mon_cnt]  = d;
          mon_cnt++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_local(input logic [HIT_W-1:0] h);
    @(posedge clk); #1;
    local_valid = 1'b1; local_hit = h;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (local_ready) break;
    end
    @(posedge clk); #1;
    local_valid = 1'b0;
  endtask

  task automatic send_rx(input int k, input logic [REC_W-1:0] r);
    @(posedge clk); #1;
    rx_valid[k] = 1'b1; rx_data[k] = r;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (rx_ready[k]) break;
    end
    @(posedge clk); #1;
    rx_valid[k] = 1'b0;
  endtask

  task automatic wait_out(input int n);
    for (int i = 0; i < 300; i++) begin
      if (mon_cnt >= n) break;
      @(negedge clk);
    end
  endtask

  // entry: dir[50:49] src[48:46] (4=local, else link) coord[45:38] payload[37:0]
  localparam logic [50:0] VEC [8] = '{
    {2'd0, 3'd4, 8'h12, 38'h01_0000_1111},
    {2'd1, 3'd0, 8'h34, 38'h3F_DEAD_BEEF},
    {2'd2, 3'd1, 8'h56, 38'h00_0000_0000},
    {2'd3, 3'd4, 8'hA7, 38'h2A_5555_AAAA},
    {2'd2, 3'd2, 8'hFF, 38'h3F_FFFF_FFFF},
    {2'd1, 3'd3, 8'h0E, 38'h15_1234_5678},
    {2'd3, 3'd4, 8'hF0, 38'h3F_FFFF_FFFF},
    {2'd0, 3'd0, 8'h9C, 38'h07_8765_4321}
  };

  initial begin
    #1_500_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    logic [REC_W-1:0] exp_r;
    logic [REC_W-1:0] l_r [3];
    logic [REC_W-1:0] r_r [3];
    int acc;

    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk(tx_valid == '0, "R1 tx_valid in reset", 64'(tx_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_valid == '0, "R1 tx_valid after reset", 64'(tx_valid), 0);
    chk(local_ready == 1'b1, "R1 local_ready", 64'(local_ready), 1);
    chk(rx_ready == 4'hF, "R1 rx_ready", 64'(rx_ready), 64'hF);

    // table walk: R2 local stamping, R3 pass-through, R4 direction
    tx_ready = 4'hF;
    foreach (VEC[i]) begin
      base = mon_cnt;
      dir_cfg = VEC[i][50:49];
      exp_r = VEC[i][45:0];
      if (VEC[i][48:46] == 3'd4) begin
        my_x = VEC[i][45:42]; my_y = VEC[i][41:38];
        send_local(VEC[i][37:0]);
      end else begin
        send_rx(int'(VEC[i][48:46]), exp_r);
      end
      wait_out(base + 1);
      chk(mon_cnt == base + 1, "R5 single delivery", 64'(mon_cnt - base), 1);
      chk(mon_data[base] == exp_r, (VEC[i][48:46] == 3'd4) ? "R2 local record" : "R3 remote record",
          64'(mon_data[base]), 64'(exp_r));
      chk(mon_dir[base] == int'(VEC[i][50:49]), "R4 output link", 64'(mon_dir[base]), 64'(VEC[i][50:49]));
    end

    // R5: backpressure hold
    tx_ready = 4'h0; dir_cfg = 2'd1; my_x = 4'h3; my_y = 4'h9;
    base = mon_cnt;
    send_local(38'h11_2222_3333);
    exp_r = {4'h3, 4'h9, 38'h11_2222_3333};
    repeat (2) @(negedge clk);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk(tx_valid == 4'b0010, "R5 valid held", 64'(tx_valid), 64'h2);
      chk(tx_data[1] == exp_r, "R5 data held", 64'(tx_data[1]), 64'(exp_r));
    end
    @(posedge clk); #1; tx_ready = 4'hF;
    repeat (4) @(negedge clk);
    chk(mon_cnt == base + 1, "R5 once after release", 64'(mon_cnt - base), 1);

    // R6: reroute while waiting
    tx_ready = 4'h0; dir_cfg = 2'd0;
    base = mon_cnt;
    send_local(38'h05_0BAD_F00D);
    repeat (3) @(negedge clk);
    chk(tx_valid == 4'b0001, "R6 before reroute", 64'(tx_valid), 64'h1);
    @(posedge clk); #1; dir_cfg = 2'd2;
    @(negedge clk);
    chk(tx_valid == 4'b0100, "R6 moved link", 64'(tx_valid), 64'h4);
    @(posedge clk); #1; tx_ready = 4'b0100;
    repeat (4) @(negedge clk);
    chk(mon_cnt == base + 1, "R6 sent once", 64'(mon_cnt - base), 1);
    chk(mon_dir[base] == 2, "R6 new link", 64'(mon_dir[base]), 2);
    @(posedge clk); #1; tx_ready = 4'hF;

    // R7: alternation under contention
    tx_ready = 4'h0; dir_cfg = 2'd1; my_x = 4'h1; my_y = 4'h2;
    base = mon_cnt;
    for (int i = 0; i < 3; i++) begin
      l_r[i] = {4'h1, 4'h2, 38'(64'h100 + i)};
      r_r[i] = 46'(64'h2000_0000_0200 + i);
      send_local(38'(64'h100 + i));
    end
    for (int i = 0; i < 3; i++) send_rx(0, r_r[i]);
    repeat (6) @(negedge clk);
    @(posedge clk); #1; tx_ready = 4'hF;
    wait_out(base + 6);
    for (int i = 0; i < 3; i++) begin
      chk(mon_data[base + 2*i] == l_r[i], "R7 local turn", 64'(mon_data[base + 2*i]), 64'(l_r[i]));
      chk(mon_data[base + 2*i + 1] == r_r[i], "R7 remote turn", 64'(mon_data[base + 2*i + 1]), 64'(r_r[i]));
    end

    // R8: local overflow
    tx_ready = 4'h0; dir_cfg = 2'd3; my_x = 4'h7; my_y = 4'h7;
    base = mon_cnt; acc = 0;
    for (int c = 0; c < 12; c++) begin
      @(posedge clk); #1;
      local_valid = 1'b1; local_hit = 38'(64'h300 + acc);
      @(negedge clk);
      if (local_ready) acc++;
    end
    @(posedge clk); #1; local_valid = 1'b0;
    chk(acc == 5, "R8 accepted count", 64'(acc), 5);
    @(negedge clk);
    chk(local_ready == 1'b0, "R8 ready low when full", 64'(local_ready), 0);
    @(posedge clk); #1; tx_ready = 4'hF;
    wait_out(base + 5);
    repeat (3) @(negedge clk);
    chk(mon_cnt == base + 5, "R8 delivered count", 64'(mon_cnt - base), 5);
    for (int i = 0; i < 5; i++) begin
      exp_r = {4'h7, 4'h7, 38'(64'h300 + i)};
      chk(mon_data[base + i] == exp_r, "R8 order", 64'(mon_data[base + i]), 64'(exp_r));
    end

    // R9/R10: simultaneous links, rotation after link 0 served last
    dir_cfg = 2'd2; base = mon_cnt;
    @(posedge clk); #1;
    for (int k = 0; k < NLINK; k++) rx_data[k] = 46'(64'h3000_0000_0400 + k);
    rx_valid = 4'hF;
    @(posedge clk); #1; rx_valid = 4'h0;
    @(negedge clk);
    chk(rx_ready == 4'hF, "R10 ready kept with room", 64'(rx_ready), 64'hF);
    wait_out(base + 4);
    for (int i = 0; i < 4; i++) begin
      exp_r = 46'(64'h3000_0000_0400 + ((i + 1) % 4));
      chk(mon_data[base + i] == exp_r, "R9 rotation", 64'(mon_data[base + i]), 64'(exp_r));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule